// File: doc/BRIEF.md
# Fixed-Step Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for a precision time protocol clock. The value is a 40-bit nanosecond count with a 32-bit sub-nanosecond fraction below it. On every tick, one reference period of 8 ns, the block adds 8 ns to the value. It also adds a signed trim in units of 2^-32 ns. The integer step is fixed. The only way to speed the clock up or slow it down is the trim, which is held as a sign bit and a 31-bit magnitude. A carry or borrow out of the fraction moves into the nanosecond field. The nanosecond field wraps modulo 2^40.

A host reaches the block through a small word-wide register port. Reading the fraction word freezes a snapshot of the nanosecond count, so the following reads of the two nanosecond words form one consistent time. Setting the time takes two words. The low word is staged, and the time changes in one step when the high word is written. Setting bit 31 of a control word holds the counter still. That bit is set out of reset, so software must clear it to start the clock.

Top module: `tod_fixed_step_timer`

## Requirements
- R1: After reset the nanosecond count, fraction, staged low word, snapshot and trim are all zero. The control word at address 4 reads 0x8000_0000, which means halted.
- R2: While control bit 31 is 1, the nanosecond count and fraction do not change.
- R3: When control bit 31 is 0 and the trim is zero, each tick adds exactly 8 to the nanosecond count and leaves the fraction unchanged.
- R4: A trim (address 3) with bit 31 = 0 adds bits 30:0 to the fraction on every tick. A carry out of the fraction adds one more nanosecond.
- R5: A trim with bit 31 = 1 subtracts bits 30:0 from the fraction on every tick. A borrow from the fraction takes one nanosecond away from the 8 ns step.
- R6: A read of address 0 returns the live fraction and captures the nanosecond count. Later reads of address 1 (bits 31:0) and address 2 return the captured count, however far the counter has moved since.
- R7: A read of address 2 returns count bits 39:32 in bits 7:0, with bits 31:8 as zero.
- R8: A write to address 1 only stages a low word and leaves the time unchanged. A write to address 2 loads the count as {wdata[7:0], staged low word} and clears the fraction, all in one cycle.
- R9: When a write to address 2 falls on a tick cycle, the load wins and that tick is lost.
- R10: The nanosecond count wraps from 2^40-1 through zero without disturbing the step.
- R11: Read data appears on host_rdata in the cycle after host_rd. The trim reads back as written. The control word reads back only its bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle by default |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register select: 0 fraction, 1 ns low, 2 ns high, 3 trim, 4 control |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after host_rd |
| tod_ns | output | 40 | Live nanosecond count |

## Verification
The bench runs positive and negative trims large enough to cross a fraction boundary within a few ticks. A design that dropped the carry, or added the magnitude when it should subtract, would report a nanosecond count off by one or two, or a wrong fraction. The bench also targets the snapshot: it lets the counter run between the fraction read and the low-word read. A design that returned live words would hand back a later time. A load is placed on a tick edge, where a design giving the tick priority would end 8 ns ahead. Writing only the low word must leave the time alone. Starting just below 2^40 must give a small count, not a value held at the top.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int NS_W    = 40;
    localparam int FRAC_W  = 32;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int STEP_NS = 8;

    localparam int TOD_W = NS_W + FRAC_W;
    localparam int HI_W  = NS_W - WORD_W;
    localparam int MAG_W = WORD_W - 1;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } trim_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_FRAC  = 3'd0,
        SEL_NS_LO = 3'd1,
        SEL_NS_HI = 3'd2,
        SEL_TRIM  = 3'd3,
        SEL_CTRL  = 3'd4
    } reg_sel_e;

    // Per-tick increment of the whole {ns, frac} value: 8 ns +/- trim.
    function automatic logic [TOD_W-1:0] tick_step(trim_t t);
        logic [TOD_W-1:0] base;
        logic [TOD_W-1:0] m;
        base = TOD_W'(STEP_NS) << FRAC_W;
        m    = TOD_W'(t.mag);
        return t.neg ? (base - m) : (base + m);
    endfunction

    function automatic tod_t tod_add(tod_t cur, logic [TOD_W-1:0] step);
        logic [TOD_W-1:0] s;
        s = cur;
        s = s + step;
        return s;
    endfunction

endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen
    import tod_pkg::*;
#(
    parameter int CLKS_PER_TICK = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R2
    halt_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

endmodule

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  load_en,
    input  tod_t  load_val,
    input  trim_t trim,
    output tod_t  now
);
    tod_t             now_q;
    logic [TOD_W-1:0] step;

    always_comb step = tick_step(trim);

    // Load has priority over the tick on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= '0;
        end else if (load_en) begin
            now_q <= load_val;
        end else if (tick) begin
            now_q <= tod_add(now_q, step);
        end
    end

    assign now = now_q;

    // R3
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en) |=> (((now_q.ns - $past(now_q.ns)) == 40'd7) ||
                                ((now_q.ns - $past(now_q.ns)) == 40'd8) ||
                                ((now_q.ns - $past(now_q.ns)) == 40'd9)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> $stable(now_q));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (now_q == $past(load_val)));

endmodule

// File: rtl/tod_host_regs.sv
module tod_host_regs
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  tod_t              now,
    output logic [WORD_W-1:0] host_rdata,
    output trim_t             trim,
    output logic              run,
    output logic              load_en,
    output tod_t              load_val
);
    reg_sel_e          sel;
    logic              halt_q;
    trim_t             trim_q;
    logic [WORD_W-1:0] lo_stage_q;
    logic [NS_W-1:0]   snap_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] rd_mux;

    assign sel = reg_sel_e'(host_addr);

    // Writes of the staging word, trim and control.
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q     <= 1'b1;
            trim_q     <= '0;
            lo_stage_q <= '0;
        end else if (host_wr) begin
            case (sel)
                SEL_NS_LO: lo_stage_q <= host_wdata;
                SEL_TRIM:  trim_q     <= trim_t'(host_wdata);
                SEL_CTRL:  halt_q     <= host_wdata[WORD_W-1];
                default:   ;
            endcase
        end
    end

    // Atomic time load on the high-word write.
    assign load_en       = host_wr && (sel == SEL_NS_HI);
    assign load_val.ns   = {host_wdata[HI_W-1:0], lo_stage_q};
    assign load_val.frac = '0;

    // Read selection.
    always_comb begin
        case (sel)
            SEL_FRAC:  rd_mux = now.frac;
            SEL_NS_LO: rd_mux = snap_q[WORD_W-1:0];
            SEL_NS_HI: rd_mux = WORD_W'(snap_q[NS_W-1:WORD_W]);
            SEL_TRIM:  rd_mux = trim_q;
            SEL_CTRL:  rd_mux = {halt_q, {(WORD_W-1){1'b0}}};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            snap_q  <= '0;
        end else if (host_rd) begin
            rdata_q <= rd_mux;
            if (sel == SEL_FRAC) begin
                snap_q <= now.ns;
            end
        end
    end

    assign host_rdata = rdata_q;
    assign trim       = trim_q;
    assign run        = !halt_q;

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && sel == SEL_FRAC) |=> $stable(snap_q));

    // R7
    hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && sel == SEL_NS_HI) |=> (host_rdata[WORD_W-1:HI_W] == '0));

    // R11
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && sel == SEL_CTRL) |=> (run == !$past(host_wdata[WORD_W-1])));

    // R8
    lo_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && sel == SEL_NS_LO) |-> !load_en);

endmodule

// File: rtl/tod_fixed_step_timer.sv
module tod_fixed_step_timer
    import tod_pkg::*;
#(
    parameter int CLKS_PER_TICK = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic [NS_W-1:0]   tod_ns
);
    tod_t  now;
    tod_t  load_val;
    trim_t trim;
    logic  run;
    logic  tick;
    logic  load_en;

    tod_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .now        (now),
        .host_rdata (host_rdata),
        .trim       (trim),
        .run        (run),
        .load_en    (load_en),
        .load_val   (load_val)
    );

    tod_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    tod_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_en  (load_en),
        .load_val (load_val),
        .trim     (trim),
        .now      (now)
    );

    assign tod_ns = now.ns;

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && (now.ns == {NS_W{1'b1}}) && !trim.neg) |=> (tod_ns < 40'd16));

endmodule

// File: tb/sim_tod_fixed_step_timer.sv
module sim_tod_fixed_step_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [39:0] tod_ns;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tod_fixed_step_timer u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .tod_ns(tod_ns)
    );

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge; one rising edge each.
    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic read_time(output logic [71:0] t);
        logic [31:0] f, lo, hi;
        bus_rd(3'd0, f);
        bus_rd(3'd1, lo);
        bus_rd(3'd2, hi);
        t = {hi[7:0], lo, f};
    endtask

    task automatic load_time(input logic [39:0] ns);
        bus_wr(3'd4, 32'h8000_0000);
        bus_wr(3'd1, ns[31:0]);
        bus_wr(3'd2, {24'h0, ns[39:32]});
    endtask

    // Start, wait n cycles, halt: n+1 ticks in total.
    task automatic run_ticks(input int n);
        bus_wr(3'd4, 32'h0);
        repeat (n) @(negedge clk);
        bus_wr(3'd4, 32'h8000_0000);
    endtask

    function automatic logic [71:0] advance(input logic [71:0] v, input logic [31:0] trim, input int n);
        logic [71:0] st;
        st = 72'd8 << 32;
        if (trim[31]) st = st - 72'(trim[30:0]);
        else          st = st + 72'(trim[30:0]);
        for (int i = 0; i < n; i++) v = v + st;
        return v;
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        logic [71:0] t;
        bus_rd(3'd4, d); chk("R1 ctrl after reset", 72'(d), 72'h8000_0000);
        bus_rd(3'd3, d); chk("R1 trim after reset", 72'(d), 72'h0);
        read_time(t);    chk("R1 time after reset", t, 72'h0);
        repeat (10) @(negedge clk);
        read_time(t);    chk("R2 halted stays zero", t, 72'h0);
        chk("R2 live ns halted", 72'(tod_ns), 72'h0);
    endtask

    task automatic t_plain_step;
        logic [71:0] t;
        load_time(40'h12_3456_0000);
        bus_wr(3'd3, 32'h0);
        run_ticks(9);
        read_time(t);
        chk("R3 ten plain ticks", t, advance({40'h12_3456_0000, 32'h0}, 32'h0, 10));
    endtask

    task automatic t_pos_trim;
        logic [71:0] t;
        load_time(40'd100);
        bus_wr(3'd3, 32'h4000_0000);
        run_ticks(4);
        read_time(t);
        chk("R4 positive trim carry", t, {40'd141, 32'h4000_0000});
        chk("R4 model agrees", t, advance({40'd100, 32'h0}, 32'h4000_0000, 5));
    endtask

    task automatic t_neg_trim;
        logic [71:0] t;
        load_time(40'd100);
        bus_wr(3'd3, 32'hC000_0000);
        run_ticks(4);
        read_time(t);
        chk("R5 negative trim borrow", t, {40'd138, 32'hC000_0000});
        load_time(40'd5000);
        bus_wr(3'd3, 32'hFFFF_FFFF);
        run_ticks(2);
        read_time(t);
        chk("R5 max negative trim", t, advance({40'd5000, 32'h0}, 32'hFFFF_FFFF, 3));
        bus_wr(3'd3, 32'h0);
    endtask

    task automatic t_snapshot;
        logic [31:0] f, lo, hi;
        load_time(40'h00_0000_1000);
        bus_wr(3'd4, 32'h0);
        repeat (3) @(negedge clk);
        bus_rd(3'd0, f);
        chk("R6 fraction read", 72'(f), 72'h0);
        repeat (10) @(negedge clk);
        bus_rd(3'd1, lo);
        chk("R6 frozen low word", 72'(lo), 72'h1018);
        bus_rd(3'd2, hi);
        chk("R6 frozen high word", 72'(hi), 72'h0);
        chk("R6 counter kept running", 72'(tod_ns > 40'h1018), 72'h1);
        bus_wr(3'd4, 32'h8000_0000);
    endtask

    task automatic t_hi_zero;
        logic [31:0] d;
        bus_wr(3'd4, 32'h8000_0000);
        bus_wr(3'd1, 32'h0000_0055);
        bus_wr(3'd2, 32'hFFFF_FFAB);
        bus_rd(3'd0, d);
        bus_rd(3'd2, d);
        chk("R7 high word upper bits zero", 72'(d), 72'h0000_00AB);
    endtask

    task automatic t_staging;
        logic [71:0] t;
        load_time(40'h01_0000_0040);
        bus_wr(3'd1, 32'hDEAD_BEEF);
        chk("R8 low write alone live", 72'(tod_ns), 72'h01_0000_0040);
        read_time(t);
        chk("R8 low write alone no effect", t, {40'h01_0000_0040, 32'h0});
        bus_wr(3'd2, 32'h0000_0077);
        read_time(t);
        chk("R8 commit on high write", t, {40'h77_DEAD_BEEF, 32'h0});
    endtask

    task automatic t_priority;
        logic [71:0] t;
        load_time(40'h10_0000_0000);
        bus_wr(3'd4, 32'h0);
        bus_wr(3'd1, 32'h2222_0000);
        bus_wr(3'd2, 32'h0000_0033);
        bus_wr(3'd4, 32'h8000_0000);
        read_time(t);
        chk("R9 load beats tick", t, {40'h33_2222_0008, 32'h0});
    endtask

    task automatic t_wrap;
        logic [71:0] t;
        bus_wr(3'd3, 32'h0);
        load_time(40'hFF_FFFF_FFF8);
        run_ticks(1);
        read_time(t);
        chk("R10 wrap through zero", t, {40'd8, 32'h0});
    endtask

    task automatic t_readback;
        logic [31:0] d;
        bus_wr(3'd3, 32'hC123_4567);
        bus_rd(3'd3, d); chk("R11 trim readback", 72'(d), 72'hC123_4567);
        bus_wr(3'd4, 32'hFFFF_FFFF);
        bus_rd(3'd4, d); chk("R11 ctrl only bit 31", 72'(d), 72'h8000_0000);
        bus_wr(3'd4, 32'h7FFF_FFFF);
        bus_rd(3'd4, d); chk("R11 ctrl cleared", 72'(d), 72'h0);
        bus_wr(3'd4, 32'h8000_0000);
        bus_wr(3'd3, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain_step();
        t_pos_trim();
        t_neg_trim();
        t_snapshot();
        t_hi_zero();
        t_staging();
        t_priority();
        t_wrap();
        t_readback();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule